// File: doc/BRIEF.md
# Double-Data-Rate Prefetch Data Path

This block sits between a memory core that moves one 32-bit word per clock and a 16-bit external data bus that moves a half-word on each clock edge. Each internal access is a prefetch pair: two 16-bit half-words travelling together as one 32-bit word.

On the write side the external controller sends a half-word and its two byte masks with each edge of a write strobe. The block captures the half-word on the strobe's rising edge and the one on its falling edge. It then hands the pair, with a 4-bit byte mask, to the core side one clock later.

On the read side the core side offers a pair together with a valid flag. The block drives the first half-word while the clock is high and the second while it is low. A strobe runs in step with the data. The strobe is framed by a low preamble before the data and a low postamble after it. All control inputs are sampled on rising clock edges only.

Top module: `ddr_prefetch_path`

## Requirements
- R1: When `wr_take` is high at rising clock edge k, the half-word captured on the next rising `wr_dqs` edge appears in `wr_word[15:0]`, and the one captured on the following falling `wr_dqs` edge appears in `wr_word[31:16]`. `wr_word_valid` is high for exactly the one clock that follows rising edge k+1.
- R2: `wr_mask[1:0]` carries the rising-edge `wr_dm` and `wr_mask[3:2]` the falling-edge `wr_dm`. Mask bit b belongs to byte b of `wr_word` (bits 8b+7:8b). A 1 blocks that byte. The bits are passed through unchanged.
- R3: Strobe edges that arrive while no `wr_take` was sampled leave `wr_word_valid` low and `wr_word` unchanged.
- R4: `wr_take` and `rd_valid` are sampled only at rising clock edges. A pulse that starts and ends between two rising edges has no effect.
- R5: When `rd_valid` is high at rising edge k, the clock from edge k+1 to k+2 is a data clock. During that clock `rd_dq_oe` and `rd_dqs_oe` are 1. During the high phase, `rd_dq` = `rd_pair[15:0]` and `rd_dqs` = 1. During the low phase, `rd_dq` = `rd_pair[31:16]` and `rd_dqs` = 0.
- R6: A data clock that is not preceded by a data clock is preceded by one preamble clock: `rd_dqs_oe` = 1, `rd_dqs` = 0, `rd_dq_oe` = 0.
- R7: The clock after the last data clock of a burst is a postamble clock: `rd_dqs_oe` = 1, `rd_dqs` = 0, `rd_dq_oe` = 0.
- R8: Pairs offered on consecutive clocks come out on consecutive data clocks, in order, with no gap and no preamble between them.
- R9: Outside preamble, data and postamble clocks, `rd_dqs_oe`, `rd_dq_oe` and `rd_dqs` are 0 and `rd_dq` is 0.
- R10: While `rst` is high, `wr_word_valid`, `wr_word`, `wr_mask`, `rd_dq_oe`, `rd_dqs_oe`, `rd_dqs` and `rd_dq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge samples control, both edges launch read data |
| rst | input | 1 | Synchronous active-high reset |
| wr_take | input | 1 | Accept the write pair sent during the coming clock |
| wr_dqs | input | 1 | Write strobe; data captured on both edges |
| wr_dq | input | 16 | Write half-word from the bus |
| wr_dm | input | 2 | Byte masks for the current write half-word |
| wr_word | output | 32 | Assembled write pair, first half-word in the low bits |
| wr_mask | output | 4 | Byte masks of the pair, 1 blocks a byte |
| wr_word_valid | output | 1 | `wr_word` and `wr_mask` hold a new pair this clock |
| rd_valid | input | 1 | A read pair is offered on `rd_pair` |
| rd_pair | input | 32 | Read pair from the core side, first half-word in the low bits |
| rd_dq | output | 16 | Read half-word to the bus |
| rd_dq_oe | output | 1 | Drive enable for `rd_dq` |
| rd_dqs | output | 1 | Read strobe, toggling with the data |
| rd_dqs_oe | output | 1 | Drive enable for `rd_dqs` |

## Verification
The bench sends write pairs whose masks are asymmetric between edges and bytes. A design that swapped the edge halves, or mapped a mask to the wrong byte, shows a wrong word or mask on the scoreboard. It sends single read pairs and a three-pair back-to-back burst, and checks each phase of each clock. A design that put the second half-word first, left a gap or a stray preamble inside a burst, or dropped the preamble or postamble fails these phase checks. Control pulses that fall wholly between rising edges, and strobe edges sent without a take, catch a design that samples control on the falling edge or lets the strobe alone publish a pair.

// File: rtl/ddr_pf_pkg.sv
package ddr_pf_pkg;

    localparam int DQ_W   = 16;
    localparam int BYTE_W = 8;
    localparam int DM_W   = DQ_W / BYTE_W;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PRE  = 2'd1,
        PH_DATA = 2'd2,
        PH_POST = 2'd3
    } rd_phase_e;

    // Phase of the coming clock, decided at a rising edge.
    // staged : a pair was accepted at the previous edge
    // incoming: a pair is being accepted at this edge
    // ending : the clock now finishing was a data clock
    function automatic rd_phase_e next_phase(input logic incoming,
                                             input logic staged,
                                             input logic ending);
        rd_phase_e ph;
        if (staged)        ph = PH_DATA;
        else if (incoming) ph = PH_PRE;
        else if (ending)   ph = PH_POST;
        else               ph = PH_IDLE;
        return ph;
    endfunction

endpackage

// File: rtl/ddr_wr_capture.sv
module ddr_wr_capture #(
    parameter int DQ_W = ddr_pf_pkg::DQ_W,
    parameter int DM_W = ddr_pf_pkg::DM_W
) (
    input  logic            dqs,
    input  logic [DQ_W-1:0] dq,
    input  logic [DM_W-1:0] dm,
    output logic [DQ_W-1:0] first_dq,
    output logic [DM_W-1:0] first_dm,
    output logic [DQ_W-1:0] second_dq,
    output logic [DM_W-1:0] second_dm
);

    // First half-word of a pair rides the rising strobe edge.
    always_ff @(posedge dqs) begin
        first_dq <= dq;
        first_dm <= dm;
    end

    // Second half-word rides the falling strobe edge.
    always_ff @(negedge dqs) begin
        second_dq <= dq;
        second_dm <= dm;
    end

endmodule

// File: rtl/ddr_wr_handoff.sv
module ddr_wr_handoff #(
    parameter int DQ_W = ddr_pf_pkg::DQ_W,
    parameter int DM_W = ddr_pf_pkg::DM_W,
    localparam int WORD_W = 2 * DQ_W,
    localparam int MASK_W = 2 * DM_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [DQ_W-1:0]   first_dq,
    input  logic [DM_W-1:0]   first_dm,
    input  logic [DQ_W-1:0]   second_dq,
    input  logic [DM_W-1:0]   second_dm,
    output logic [WORD_W-1:0] word,
    output logic [MASK_W-1:0] mask,
    output logic              valid
);

    typedef struct packed {
        logic [DQ_W-1:0] second;
        logic [DQ_W-1:0] first;
    } wr_pair_t;

    logic     take_q;
    wr_pair_t pair_d;

    assign pair_d = '{second: second_dq, first: first_dq};

    // Control taken on the rising clock edge only; the pair sent during
    // the following clock is transferred one edge later.
    always_ff @(posedge clk) begin
        if (rst) begin
            take_q <= 1'b0;
            valid  <= 1'b0;
            word   <= '0;
            mask   <= '0;
        end else begin
            take_q <= take;
            valid  <= take_q;
            if (take_q) begin
                word <= pair_d;
                mask <= {second_dm, first_dm};
            end
        end
    end

endmodule

// File: rtl/ddr_rd_launch.sv
module ddr_rd_launch
    import ddr_pf_pkg::*;
#(
    parameter int DQ_W = ddr_pf_pkg::DQ_W,
    localparam int WORD_W = 2 * DQ_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_pair,
    output logic [DQ_W-1:0]   dq,
    output logic              dq_oe,
    output logic              dqs,
    output logic              dqs_oe
);

    typedef struct packed {
        logic [DQ_W-1:0] second;
        logic [DQ_W-1:0] first;
    } rd_pair_t;

    logic      s1_v;
    rd_pair_t  s1_p;
    rd_pair_t  s2_p;
    rd_phase_e ph_q;
    logic [DQ_W-1:0] fall_q;
    logic      data_on;

    assign data_on = (ph_q == PH_DATA);

    // Rising-edge stages: accept, then launch.
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v <= 1'b0;
            s1_p <= '0;
            s2_p <= '0;
            ph_q <= PH_IDLE;
        end else begin
            s1_v <= rd_valid;
            if (rd_valid) s1_p <= rd_pair;
            if (s1_v)     s2_p <= s1_p;
            ph_q <= next_phase(rd_valid, s1_v, data_on);
        end
    end

    // Falling-edge launch register for the second half-word.
    always_ff @(negedge clk) begin
        if (rst) fall_q <= '0;
        else     fall_q <= s2_p.second;
    end

    assign dq_oe  = data_on;
    assign dqs_oe = (ph_q != PH_IDLE);
    assign dqs    = data_on & clk;
    assign dq     = data_on ? (clk ? s2_p.first : fall_q) : '0;

endmodule

// File: rtl/ddr_prefetch_path.sv
module ddr_prefetch_path #(
    parameter int DQ_W = ddr_pf_pkg::DQ_W,
    localparam int DM_W   = DQ_W / ddr_pf_pkg::BYTE_W,
    localparam int WORD_W = 2 * DQ_W,
    localparam int MASK_W = 2 * DM_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_take,
    input  logic              wr_dqs,
    input  logic [DQ_W-1:0]   wr_dq,
    input  logic [DM_W-1:0]   wr_dm,
    output logic [WORD_W-1:0] wr_word,
    output logic [MASK_W-1:0] wr_mask,
    output logic              wr_word_valid,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_pair,
    output logic [DQ_W-1:0]   rd_dq,
    output logic              rd_dq_oe,
    output logic              rd_dqs,
    output logic              rd_dqs_oe
);

    logic [DQ_W-1:0] cap_first_dq;
    logic [DM_W-1:0] cap_first_dm;
    logic [DQ_W-1:0] cap_second_dq;
    logic [DM_W-1:0] cap_second_dm;

    ddr_wr_capture #(.DQ_W(DQ_W), .DM_W(DM_W)) u_wr_capture (
        .dqs       (wr_dqs),
        .dq        (wr_dq),
        .dm        (wr_dm),
        .first_dq  (cap_first_dq),
        .first_dm  (cap_first_dm),
        .second_dq (cap_second_dq),
        .second_dm (cap_second_dm)
    );

    ddr_wr_handoff #(.DQ_W(DQ_W), .DM_W(DM_W)) u_wr_handoff (
        .clk       (clk),
        .rst       (rst),
        .take      (wr_take),
        .first_dq  (cap_first_dq),
        .first_dm  (cap_first_dm),
        .second_dq (cap_second_dq),
        .second_dm (cap_second_dm),
        .word      (wr_word),
        .mask      (wr_mask),
        .valid     (wr_word_valid)
    );

    ddr_rd_launch #(.DQ_W(DQ_W)) u_rd_launch (
        .clk      (clk),
        .rst      (rst),
        .rd_valid (rd_valid),
        .rd_pair  (rd_pair),
        .dq       (rd_dq),
        .dq_oe    (rd_dq_oe),
        .dqs      (rd_dqs),
        .dqs_oe   (rd_dqs_oe)
    );

endmodule

// File: rtl/ddr_prefetch_path_chk.sv
module ddr_prefetch_path_chk #(
    parameter int DQ_W = ddr_pf_pkg::DQ_W,
    localparam int DM_W   = DQ_W / ddr_pf_pkg::BYTE_W,
    localparam int WORD_W = 2 * DQ_W,
    localparam int MASK_W = 2 * DM_W
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_take,
    input logic              wr_dqs,
    input logic [DQ_W-1:0]   wr_dq,
    input logic [DM_W-1:0]   wr_dm,
    input logic [WORD_W-1:0] wr_word,
    input logic [MASK_W-1:0] wr_mask,
    input logic              wr_word_valid,
    input logic              rd_valid,
    input logic [WORD_W-1:0] rd_pair,
    input logic [DQ_W-1:0]   rd_dq,
    input logic              rd_dq_oe,
    input logic              rd_dqs,
    input logic              rd_dqs_oe
);

    AST_WR_VALID_FROM_TAKE: assert property (@(posedge clk) disable iff (rst)
        wr_word_valid |-> $past(wr_take, 2)); // R1

    AST_WR_HOLD_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
        !wr_word_valid |-> ($stable(wr_word) && $stable(wr_mask))); // R3

    AST_RD_DATA_CLOCK: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> ##1 rd_dq_oe); // R5

    AST_RD_PREAMBLE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> rd_dqs_oe); // R6

    AST_RD_POSTAMBLE: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_dq_oe) |-> (rd_dqs_oe && !rd_dqs)); // R7

    AST_RD_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rd_dqs_oe |-> (!rd_dq_oe && !rd_dqs && rd_dq == '0)); // R9

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!wr_word_valid && !rd_dq_oe && !rd_dqs_oe)); // R10

endmodule

bind ddr_prefetch_path ddr_prefetch_path_chk #(.DQ_W(DQ_W)) u_chk (.*);

// File: tb/ddr_prefetch_path_bench.sv
module ddr_prefetch_path_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_take = 1'b0;
    logic        wr_dqs = 1'b0;
    logic [15:0] wr_dq = '0;
    logic [1:0]  wr_dm = '0;
    logic [31:0] wr_word;
    logic [3:0]  wr_mask;
    logic        wr_word_valid;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_pair = '0;
    logic [15:0] rd_dq;
    logic        rd_dq_oe;
    logic        rd_dqs;
    logic        rd_dqs_oe;

    ddr_prefetch_path u_ddr_prefetch_path (.*);

    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int fails  = 0;
    int wr_seen = 0;
    int rd_seen = 0;
    bit done = 1'b0;

    logic [31:0] wr_q_word[$];
    logic [3:0]  wr_q_mask[$];
    logic [31:0] rd_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: one write pair, strobe quarter-cycle shifted from the clock.
    task automatic send_write(input logic [15:0] d0, input logic [1:0] m0,
                              input logic [15:0] d1, input logic [1:0] m1);
        @(negedge clk);
        wr_take = 1'b1;
        @(posedge clk);
        #1 wr_take = 1'b0;
        #1 wr_dq = d0; wr_dm = m0;
        #3 wr_dqs = 1'b1;
        #5 wr_dq = d1; wr_dm = m1;
        #5 wr_dqs = 1'b0;
        wr_q_word.push_back({d1, d0});
        wr_q_mask.push_back({m1, m0});
    endtask

    // Driver: n pairs on consecutive clocks.
    task automatic send_reads(input int n, input logic [31:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd_valid = 1'b1;
            rd_pair  = base + 32'h0111_0111 * i;
            rd_q.push_back(base + 32'h0111_0111 * i);
        end
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    // Write monitor.
    always @(negedge clk) begin
        if (!rst && wr_word_valid) begin
            wr_seen++;
            if (wr_q_word.size() == 0) begin
                chk(1'b0, "R4", "unexpected write pair", wr_word, 32'h0);
            end else begin
                logic [31:0] ew;
                logic [3:0]  em;
                ew = wr_q_word.pop_front();
                em = wr_q_mask.pop_front();
                chk(wr_word == ew, "R1", "write pair order", wr_word, ew);
                chk(wr_mask == em, "R2", "write mask", {28'h0, wr_mask}, {28'h0, em});
            end
        end
    end

    // Read monitor: high phase then low phase of every clock.
    initial begin
        logic prev_dq_oe, prev_dqs_oe, prev_dqs;
        logic [31:0] exp;
        prev_dq_oe = 0; prev_dqs_oe = 0; prev_dqs = 0;
        forever begin
            @(posedge clk);
            #5;
            if (rst) begin
                prev_dq_oe = 0; prev_dqs_oe = 0; prev_dqs = 0;
                continue;
            end
            if (rd_dq_oe) begin
                rd_seen++;
                if (rd_q.size() == 0) begin
                    chk(1'b0, "R4", "unexpected read data", {16'h0, rd_dq}, 32'h0);
                    exp = '0;
                end else begin
                    exp = rd_q.pop_front();
                    if (prev_dq_oe)
                        chk(rd_dq == exp[15:0], "R8", "burst first half", {16'h0, rd_dq}, {16'h0, exp[15:0]});
                    else
                        chk(rd_dq == exp[15:0], "R5", "first half on high phase", {16'h0, rd_dq}, {16'h0, exp[15:0]});
                end
                chk(rd_dqs == 1'b1 && rd_dqs_oe, "R5", "strobe high in high phase", {31'h0, rd_dqs}, 32'h1);
                if (!prev_dq_oe)
                    chk(prev_dqs_oe && !prev_dqs, "R6", "preamble before data", {31'h0, prev_dqs_oe}, 32'h1);
                prev_dq_oe = rd_dq_oe; prev_dqs_oe = rd_dqs_oe; prev_dqs = rd_dqs;
                @(negedge clk);
                #5;
                chk(rd_dq == exp[31:16], "R5", "second half on low phase", {16'h0, rd_dq}, {16'h0, exp[31:16]});
                chk(rd_dqs == 1'b0 && rd_dq_oe, "R5", "strobe low in low phase", {31'h0, rd_dqs}, 32'h0);
            end else begin
                if (prev_dq_oe)
                    chk(rd_dqs_oe && !rd_dqs, "R7", "postamble after data", {30'h0, rd_dqs_oe, rd_dqs}, 32'h2);
                else if (!rd_dqs_oe)
                    chk(rd_dq == '0 && !rd_dqs, "R9", "idle bus quiet", {15'h0, rd_dqs, rd_dq}, 32'h0);
                prev_dq_oe = rd_dq_oe; prev_dqs_oe = rd_dqs_oe; prev_dqs = rd_dqs;
            end
        end
    end

    // Watchdog.
    initial begin
        #(20 * 20000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired: actual 1 expected 0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int seen_w, seen_r;
        logic [31:0] held_word;
        logic [3:0]  held_mask;

        repeat (3) @(negedge clk);
        chk(!wr_word_valid && wr_word == '0 && wr_mask == '0, "R10", "write side in reset",
            wr_word, 32'h0);
        chk(!rd_dq_oe && !rd_dqs_oe && !rd_dqs && rd_dq == '0, "R10", "read side in reset",
            {13'h0, rd_dq_oe, rd_dqs_oe, rd_dqs, rd_dq}, 32'h0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 R2: write pairs with varied masks
        send_write(16'h1234, 2'b00, 16'hABCD, 2'b00);
        repeat (3) @(negedge clk);
        send_write(16'h00FF, 2'b01, 16'hFF00, 2'b10);
        repeat (3) @(negedge clk);
        send_write(16'h5A5A, 2'b11, 16'hA5A5, 2'b01);
        repeat (4) @(negedge clk);

        // R3: strobe edges without a take
        held_word = wr_word;
        held_mask = wr_mask;
        seen_w = wr_seen;
        @(posedge clk);
        #2 wr_dq = 16'hDEAD; wr_dm = 2'b10;
        #3 wr_dqs = 1'b1;
        #5 wr_dq = 16'hBEEF; wr_dm = 2'b01;
        #5 wr_dqs = 1'b0;
        repeat (4) @(negedge clk);
        chk(wr_seen == seen_w, "R3", "no pair without take", wr_seen, seen_w);
        chk(wr_word == held_word && wr_mask == held_mask, "R3", "word held", wr_word, held_word);

        // R5 R6 R7: single read pair
        send_reads(1, 32'hCAFE_0001);
        repeat (5) @(negedge clk);
        // R8: back-to-back burst
        send_reads(3, 32'h1357_2468);
        repeat (5) @(negedge clk);

        // R4: control pulses wholly between rising edges
        seen_w = wr_seen;
        seen_r = rd_seen;
        @(posedge clk);
        #3 wr_take = 1'b1; rd_valid = 1'b1; rd_pair = 32'hFFFF_FFFF;
        #4 wr_take = 1'b0; rd_valid = 1'b0;
        repeat (5) @(negedge clk);
        chk(wr_seen == seen_w, "R4", "write pulse between edges ignored", wr_seen, seen_w);
        chk(rd_seen == seen_r, "R4", "read pulse between edges ignored", rd_seen, seen_r);
        chk(!rd_dqs_oe, "R4", "strobe stays off", {31'h0, rd_dqs_oe}, 32'h0);

        // another single pair after the pulse
        send_reads(1, 32'h8001_7FFE);
        repeat (5) @(negedge clk);

        chk(wr_q_word.size() == 0, "R1", "all write pairs delivered", wr_q_word.size(), 0);
        chk(rd_q.size() == 0, "R5", "all read pairs delivered", rd_q.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule